// File: doc/BRIEF.md
# Interleaved Switching Timebase with External Sync Fallback

This block is the digital timebase of a two-phase switching regulator controller. It runs from a fast system clock and divides it down to the switching period. Each period it emits a cycle-start pulse for the first phase and, half a period later, one for the second phase. It also drives a square clock that is displaced by a quarter period, so a second controller can lock to it and the two parts together place four phases evenly around the cycle. For each phase it also provides an on-permission window that closes before 85% of the period has elapsed. Downstream modulators use this window as a hard ceiling on high-side conduction.

With no external reference, the period comes from a programmed default value. An external sync input passes through a two-flop synchroniser and a pulse-width filter. The block then measures the time between rising edges of the filtered level. After three agreeing, in-range periods, the timebase adopts the measured period and snaps its phase to each sync edge. If the edges stop, or a period falls outside the legal range, lock is released and the timebase returns to the programmed default. All pins are plain control and status levels or pulses. No streaming data crosses the boundary, so no valid/ready handshake exists and no back-pressure applies.

The on-permission window is computed as floor(P*217/256) cycles, where P is the active period in system clocks. P is latched at each cycle start, so a new period never takes effect mid-cycle except when a locked sync edge realigns the counter.

Top module: `ilv_timebase`

## Requirements
- R1: While rst_n is low, every output is 0. In the first cycle after the first clock edge following release, ch1_start is 1.
- R2: When not locked, ch1_start pulses for one cycle every P cycles, where P = max(dflt_period, 4). A changed default takes effect from the next cycle start.
- R3: ch2_start pulses exactly floor(P/2) cycles after each ch1_start, and the two pulses never coincide.
- R4: Counting the ch1_start cycle as cycle 0, clk_quad is high from cycle floor(P/4) up to, but not including, cycle floor(P/4)+floor(P/2), and low elsewhere in the period.
- R5: ch1_on_ok is high for exactly floor(P*217/256) cycles, beginning with the ch1_start cycle. ch2_on_ok behaves the same way, starting from the ch2_start cycle.
- R6: A level change on sync_in that lasts fewer than 13 system clocks (MIN_PULSE) is ignored, whether the glitch is high or low.
- R7: A measured period outside the range 83 to 625 clocks (PER_MIN..PER_MAX) clears lock, and the period stays at the default.
- R8: ext_lock rises only in the cycle after a filtered rising edge that completes three consecutive accepted periods. Each accepted period must differ from the previous one by no more than the previous period shifted right by 4. A larger deviation clears lock.
- R9: While locked, ch1_start spacing equals the sync period, and ch1_start follows each sync_in rising edge by MIN_PULSE+3 clocks. This is counted from the clock after sync_in changes.
- R10: While locked, if no filtered rising edge arrives within floor(1.5*last period) clocks, ext_lock clears on the next clock and the default period returns at the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dflt_period | input | CW (12) | Programmed default period in system clocks |
| sync_in | input | 1 | Asynchronous external sync reference |
| ch1_start | output | 1 | Phase-1 cycle-start pulse |
| ch2_start | output | 1 | Phase-2 cycle-start pulse, half a period later |
| clk_quad | output | 1 | Square clock shifted a quarter period, for chaining |
| ch1_on_ok | output | 1 | Phase-1 maximum on-time window |
| ch2_on_ok | output | 1 | Phase-2 maximum on-time window |
| ext_lock | output | 1 | Timebase is following the external reference |

## Verification
While locked, a filtered sync edge and the counter's natural terminal count land in the same cycle every period. Both try to restart the cycle and reload the period. The bench provokes this by holding a steady external period after lock. It judges the result by requiring ch1_start spacing to equal the sync period exactly, with ch1_start at a fixed offset from the sync edge, so any doubled or skipped start shows up. A second overlap occurs when a lock-completing or lock-breaking edge arrives. The bench steps the sync period by an amount inside and then outside the agreement window and checks ext_lock a fixed number of cycles later.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_HUNT = 2'd1,
    TRK_LOCK = 2'd2
  } trk_state_e;

  localparam int unsigned ON_FRAC_BITS = 8;
endpackage

// File: rtl/ilv_sync_filter.sv
module ilv_sync_filter #(
  parameter int unsigned MIN_PULSE = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_rise
);
  localparam int unsigned FW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;

  logic          s1, s2, lvl;
  logic [FW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      lvl       <= 1'b0;
      run_cnt   <= '0;
      sync_rise <= 1'b0;
    end else begin
      s1        <= sync_in;
      s2        <= s1;
      sync_rise <= 1'b0;
      if (s2 != lvl) begin
        if (run_cnt == FW'(MIN_PULSE - 1)) begin
          lvl       <= s2;
          run_cnt   <= '0;
          sync_rise <= s2;
        end else begin
          run_cnt <= run_cnt + FW'(1);
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ilv_period_track.sv
module ilv_period_track
  import ilv_pkg::*;
#(
  parameter int unsigned CW      = 12,
  parameter int unsigned PER_MIN = 83,
  parameter int unsigned PER_MAX = 625
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rise,
  output logic          ext_lock,
  output logic [CW-1:0] ext_per
);
  localparam int unsigned IDLE_LIM = PER_MAX + PER_MAX / 2;

  trk_state_e    st;
  logic [CW-1:0] gap, last, diff;
  logic [CW:0]   gap_lim;
  logic [1:0]    agree;
  logic          in_rng, close, missing;

  always_comb begin
    in_rng  = (gap >= CW'(PER_MIN)) && (gap <= CW'(PER_MAX));
    diff    = (gap > last) ? (gap - last) : (last - gap);
    close   = diff <= (last >> 4);
    gap_lim = (agree == 2'd0 && st != TRK_LOCK) ? (CW+1)'(IDLE_LIM)
                                                : ({1'b0, last} + {2'b00, last[CW-1:1]});
    missing = (st != TRK_IDLE) && !sync_rise && ({1'b0, gap} > gap_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TRK_IDLE;
      gap   <= '0;
      last  <= '0;
      agree <= 2'd0;
    end else begin
      if (sync_rise)      gap <= CW'(1);
      else if (gap != '1) gap <= gap + CW'(1);

      if (sync_rise) begin
        if (st == TRK_IDLE) begin
          st    <= TRK_HUNT;
          agree <= 2'd0;
        end else if (!in_rng) begin
          st    <= TRK_HUNT;
          agree <= 2'd0;
        end else if (agree == 2'd0 && st != TRK_LOCK) begin
          last  <= gap;
          agree <= 2'd1;
        end else if (close) begin
          last <= gap;
          if (st == TRK_LOCK || agree == 2'd2) st <= TRK_LOCK;
          else agree <= agree + 2'd1;
        end else begin
          last  <= gap;
          agree <= 2'd1;
          st    <= TRK_HUNT;
        end
      end else if (missing) begin
        st    <= TRK_IDLE;
        agree <= 2'd0;
      end
    end
  end

  assign ext_lock = (st == TRK_LOCK);
  assign ext_per  = last;
endmodule

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen
  import ilv_pkg::*;
#(
  parameter int unsigned CW        = 12,
  parameter int unsigned PER_FLOOR = 4,
  parameter int unsigned ON_NUM    = 217
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] dflt_period,
  input  logic [CW-1:0] ext_per,
  input  logic          ext_lock,
  input  logic          sync_rise,
  output logic          ch1_start,
  output logic          ch2_start,
  output logic          clk_quad,
  output logic          ch1_on_ok,
  output logic          ch2_on_ok
);
  localparam int unsigned NPH = 2;
  localparam int unsigned PW  = CW + ON_FRAC_BITS;

  logic [CW-1:0] ph, per_cur, sel_raw, sel, half, qtr, lim;
  logic [PW-1:0] prod;
  logic          run, realign, wrap;
  logic [CW-1:0] offs  [NPH];
  logic [NPH-1:0] start_v, on_v;

  always_comb begin
    sel_raw = ext_lock ? ext_per : dflt_period;
    sel     = (sel_raw < CW'(PER_FLOOR)) ? CW'(PER_FLOOR) : sel_raw;
    realign = ext_lock && sync_rise;
    wrap    = realign || (({1'b0, ph} + (CW+1)'(1)) >= {1'b0, per_cur});
    run     = (per_cur != '0);
    half    = per_cur >> 1;
    qtr     = per_cur >> 2;
    prod    = {{ON_FRAC_BITS{1'b0}}, per_cur} * PW'(ON_NUM);
    lim     = prod[PW-1:ON_FRAC_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      per_cur <= '0;
    end else if (wrap) begin
      ph      <= '0;
      per_cur <= sel;
    end else begin
      ph <= ph + CW'(1);
    end
  end

  assign offs[0] = '0;
  assign offs[1] = half;

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    logic [CW-1:0] rel;
    always_comb begin
      rel = (ph >= offs[g]) ? (ph - offs[g]) : (ph + (per_cur - offs[g]));
    end
    assign start_v[g] = run && (ph == offs[g]);
    assign on_v[g]    = run && (rel < lim);
  end

  assign ch1_start = start_v[0];
  assign ch2_start = start_v[1];
  assign ch1_on_ok = on_v[0];
  assign ch2_on_ok = on_v[1];
  assign clk_quad  = run && (ph >= qtr) && ({1'b0, ph} < ({1'b0, qtr} + {1'b0, half}));
endmodule

// File: rtl/ilv_timebase.sv
module ilv_timebase
  import ilv_pkg::*;
#(
  parameter int unsigned CW        = 12,
  parameter int unsigned MIN_PULSE = 13,
  parameter int unsigned PER_MIN   = 83,
  parameter int unsigned PER_MAX   = 625,
  parameter int unsigned PER_FLOOR = 4,
  parameter int unsigned ON_NUM    = 217
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] dflt_period,
  input  logic          sync_in,
  output logic          ch1_start,
  output logic          ch2_start,
  output logic          clk_quad,
  output logic          ch1_on_ok,
  output logic          ch2_on_ok,
  output logic          ext_lock
);
  logic          sync_rise;
  logic [CW-1:0] ext_per;

  ilv_sync_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_rise(sync_rise)
  );

  ilv_period_track #(.CW(CW), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_trk (
    .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise),
    .ext_lock(ext_lock), .ext_per(ext_per)
  );

  ilv_phase_gen #(.CW(CW), .PER_FLOOR(PER_FLOOR), .ON_NUM(ON_NUM)) u_ph (
    .clk(clk), .rst_n(rst_n), .dflt_period(dflt_period), .ext_per(ext_per),
    .ext_lock(ext_lock), .sync_rise(sync_rise),
    .ch1_start(ch1_start), .ch2_start(ch2_start), .clk_quad(clk_quad),
    .ch1_on_ok(ch1_on_ok), .ch2_on_ok(ch2_on_ok)
  );
endmodule

// File: rtl/ilv_timebase_chk.sv
module ilv_timebase_chk (
  input logic clk,
  input logic rst_n,
  input logic ch1_start,
  input logic ch2_start,
  input logic clk_quad,
  input logic ch1_on_ok,
  input logic ch2_on_ok,
  input logic ext_lock,
  input logic sync_rise
);
  AST_NO_DUAL_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch1_start && ch2_start)); // R3
  AST_ON1_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_start |-> ch1_on_ok); // R5
  AST_ON2_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_start |-> ch2_on_ok); // R5
  AST_QUAD_LOW_AT_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_start |-> !clk_quad); // R4
  AST_QUAD_HIGH_AT_CH2: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_start |-> clk_quad); // R4
  AST_LOCK_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_lock) |-> $past(sync_rise)); // R8
  AST_REALIGN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lock && sync_rise) |=> ch1_start); // R9
endmodule

bind ilv_timebase ilv_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch1_start(ch1_start), .ch2_start(ch2_start),
  .clk_quad(clk_quad), .ch1_on_ok(ch1_on_ok), .ch2_on_ok(ch2_on_ok),
  .ext_lock(ext_lock), .sync_rise(sync_rise)
);

// File: tb/ilv_timebase_test.sv
`timescale 1ns/1ps
module ilv_timebase_test;
  localparam int CW = 12;
  localparam int MINP = 13;
  localparam int NV = 5;
  // stimulus default period, expected effective period
  localparam int VEC [NV][2] = '{'{100, 100}, '{101, 101}, '{250, 250}, '{37, 37}, '{2, 4}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] dflt_period = CW'(100);
  logic sync_in;
  logic ch1_start, ch2_start, clk_quad, ch1_on_ok, ch2_on_ok, ext_lock;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int sync_per = 0;
  bit glitch = 1'b0;
  int sync_edges = 0;
  int m_per, m_c2, m_qr, m_qf, m_o1, m_o2;

  always #4 clk = ~clk;

  ilv_timebase uut (
    .clk(clk), .rst_n(rst_n), .dflt_period(dflt_period), .sync_in(sync_in),
    .ch1_start(ch1_start), .ch2_start(ch2_start), .clk_quad(clk_quad),
    .ch1_on_ok(ch1_on_ok), .ch2_on_ok(ch2_on_ok), .ext_lock(ext_lock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure();
    int k;
    m_per = -1; m_c2 = -1; m_qr = -1; m_qf = -1; m_o1 = -1; m_o2 = -1;
    k = 0;
    while (!ch1_start && k < 5000) begin @(negedge clk); k++; end
    k = 0;
    while ((m_per < 0 || m_o2 < 0) && k < 5000) begin
      @(negedge clk); k++;
      if (ch2_start && m_c2 < 0) m_c2 = k;
      if (clk_quad && m_qr < 0) m_qr = k;
      if (!clk_quad && m_qr >= 0 && m_qf < 0) m_qf = k;
      if (!ch1_on_ok && m_o1 < 0) m_o1 = k;
      if (m_c2 >= 0 && k > m_c2 && !ch2_on_ok && m_o2 < 0) m_o2 = k - m_c2;
      if (ch1_start && m_per < 0) m_per = k;
    end
  endtask

  task automatic wait_edges(input int n);
    int e;
    e = sync_edges;
    wait (sync_edges == e + n);
  endtask

  // sync driver
  initial begin
    sync_in = 1'b0;
    forever begin
      if (sync_per == 0) begin
        @(negedge clk); sync_in = 1'b0;
      end else begin
        int p, h;
        p = sync_per; h = p / 2;
        @(negedge clk); sync_in = 1'b1; sync_edges++;
        for (int i = 1; i < h; i++) begin
          @(negedge clk); sync_in = (glitch && i >= 20 && i < 28) ? 1'b0 : 1'b1;
        end
        for (int i = 0; i < p - h; i++) begin
          @(negedge clk); sync_in = (glitch && i >= 30 && i < 38) ? 1'b1 : 1'b0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, k;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ch1_start in reset", int'(ch1_start), 0);
    chk("R1 ch2_start in reset", int'(ch2_start), 0);
    chk("R1 clk_quad in reset", int'(clk_quad), 0);
    chk("R1 on_ok in reset", int'(ch1_on_ok | ch2_on_ok), 0);
    chk("R1 ext_lock in reset", int'(ext_lock), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first start after release", int'(ch1_start), 1);

    // vector table: default periods
    for (int v = 0; v < NV; v++) begin
      dflt_period = CW'(VEC[v][0]);
      p = VEC[v][1];
      measure();
      measure();
      chk("R2 period", m_per, p);
      chk("R3 ch2 offset", m_c2, p / 2);
      chk("R4 quad rise", m_qr, p / 4);
      chk("R4 quad fall", m_qf, p / 4 + p / 2);
      chk("R5 ch1 on window", m_o1, (p * 217) / 256);
      chk("R5 ch2 on window", m_o2, (p * 217) / 256);
    end

    dflt_period = CW'(100);
    measure();

    // R8 lock acquisition at 160
    sync_per = 160;
    wait (sync_edges == 3);
    repeat (40) @(negedge clk);
    chk("R8 no lock after two periods", int'(ext_lock), 0);
    wait (sync_edges == 4);
    repeat (30) @(negedge clk);
    chk("R8 lock after three periods", int'(ext_lock), 1);

    // R9 alignment and period follow
    wait_edges(2);
    k = 0;
    while (!ch1_start && k < 400) begin @(negedge clk); k++; end
    chk("R9 start offset from sync edge", k, MINP + 3);
    measure();
    chk("R9 period follows sync", m_per, 160);
    chk("R3 ch2 offset locked", m_c2, 80);

    // R6 short glitches ignored
    glitch = 1'b1;
    wait_edges(3);
    repeat (30) @(negedge clk);
    chk("R6 lock kept through glitches", int'(ext_lock), 1);
    measure();
    chk("R6 period unchanged by glitches", m_per, 160);
    glitch = 1'b0;

    // R8 small step stays locked
    sync_per = 168;
    wait_edges(3);
    repeat (30) @(negedge clk);
    chk("R8 small step keeps lock", int'(ext_lock), 1);
    measure();
    chk("R9 period follows 168", m_per, 168);

    // R8 large step drops lock
    sync_per = 190;
    wait_edges(2);
    repeat (30) @(negedge clk);
    chk("R8 large step clears lock", int'(ext_lock), 0);

    // relock at 160, then R10 missing edges
    sync_per = 160;
    wait_edges(6);
    repeat (30) @(negedge clk);
    chk("R9 relock at 160", int'(ext_lock), 1);
    wait_edges(1);
    sync_per = 0;
    repeat (200) @(negedge clk);
    chk("R10 lock held before timeout", int'(ext_lock), 1);
    repeat (100) @(negedge clk);
    chk("R10 lock cleared after timeout", int'(ext_lock), 0);
    measure();
    chk("R10 default period restored", m_per, 100);

    // R7 out-of-range period
    sync_per = 60;
    wait_edges(8);
    repeat (30) @(negedge clk);
    chk("R7 no lock on short period", int'(ext_lock), 0);
    measure();
    chk("R7 default period kept", m_per, 100);
    sync_per = 0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule